// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block takes a DRAM device from power-up to the ready state. It first holds the device reset pin low with clock enable low. It then releases reset and waits with clock enable still low. After it raises clock enable, it writes the seven mode registers in a fixed order that is not numeric. Next it issues a long ZQ calibration command and waits out the calibration time. Finally it raises a training-start level toward an external training engine and waits for that engine to report completion.

Every wait is a clock-count parameter. A simulation can use short waits, and silicon uses values derived from the device clock. The value for each mode register comes from an input array indexed by register number and is passed through without interpretation. A synchronous restart input sends the whole sequence back to the reset-asserted phase from any state.

Top module: `dram_init_seq`

## Requirements
- R1: After `rst_ni` is released, `dram_rst_no` is low for exactly RESET_WAIT clock cycles and then stays high until the next restart.
- R2: `cke_o` is low whenever `dram_rst_no` is low, stays low for exactly CKE_WAIT cycles after `dram_rst_no` rises, and then goes high.
- R3: In the cycle `cke_o` first goes high, the first mode-register command is issued (`cmd_valid_o`=1, `cmd_op_o`=1). The seven commands carry `mr_idx_o` values 3, 6, 5, 4, 2, 1, 0 in that order.
- R4: Consecutive mode-register commands are exactly MRS_GAP cycles apart, and each command lasts one cycle.
- R5: During a mode-register command, `mr_val_o` equals the entry of `mr_val_i` selected by `mr_idx_o`, where entry i occupies bits [i*MR_W +: MR_W].
- R6: MRS_GAP cycles after the index-0 command, a one-cycle calibration command is issued (`cmd_op_o`=2, `mr_idx_o`=0, `mr_val_o`=0). `train_start_o` rises ZQ_WAIT cycles after that command.
- R7: `train_start_o` stays high until `train_done_i` is sampled high. In the next cycle `init_done_o` is high and `train_start_o` is low.
- R8: `init_done_o` is low until training completes and then stays high until a restart. `train_done_i` has no effect outside the training phase.
- R9: `restart_i` sampled high in any state, including a command cycle or the cycle `train_done_i` is high, makes the next cycle a fresh reset-asserted phase with `init_done_o` low, and the full sequence repeats.
- R10: In every cycle without a command, `cmd_valid_o`=0, `cmd_op_o`=0, `mr_idx_o`=0 and `mr_val_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous restart of the power-up sequence |
| mr_val_i | input | 7*MR_W | Mode-register values, entry i for register i |
| train_done_i | input | 1 | Training engine has finished |
| dram_rst_no | output | 1 | Device reset pin, active low |
| cke_o | output | 1 | Device clock enable |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 2 | 0 none, 1 mode-register write, 2 long calibration |
| mr_idx_o | output | 3 | Mode-register number of the command |
| mr_val_o | output | MR_W | Value written by the command |
| train_start_o | output | 1 | Level request to start training |
| init_done_o | output | 1 | Device is initialized and ready |

## Verification
A restart can coincide with two other events: a command-issue cycle and the cycle in which training completes. The bench raises `restart_i` in the same cycle as the third mode-register strobe. It expects that strobe to appear intact and the next cycle to be a clean reset-asserted phase with no leftover command. It also raises `restart_i` together with `train_done_i` while training runs. In that case the restart must win, `init_done_o` must stay low, and the following run must replay the full timeline cycle by cycle.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;
  localparam int unsigned NUM_MR   = 7;
  localparam int unsigned MR_IDX_W = 3;
  localparam int unsigned STEP_W   = 3;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_MRS  = 2'd1,
    OP_ZQCL = 2'd2
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_CKE_WAIT,
    ST_MRS,
    ST_ZQ,
    ST_TRAIN,
    ST_DONE
  } init_st_e;
endpackage

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             first_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (cnt_q != '1)       cnt_q <= cnt_q + CNT_W'(1);
  end

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == limit_i - CNT_W'(1));
endmodule

// File: rtl/dram_init_mr_order.sv
module dram_init_mr_order
  import dram_init_pkg::*;
(
  input  logic [STEP_W-1:0]   step_i,
  output logic [MR_IDX_W-1:0] idx_o,
  output logic                last_o
);
  // step -> register: 3, 6, then descending 5..4, then 2..0
  always_comb begin
    if (step_i == STEP_W'(0))      idx_o = MR_IDX_W'(3);
    else if (step_i == STEP_W'(1)) idx_o = MR_IDX_W'(6);
    else if (step_i < STEP_W'(4))  idx_o = MR_IDX_W'(7) - MR_IDX_W'(step_i);
    else                           idx_o = MR_IDX_W'(6) - MR_IDX_W'(step_i);
  end

  assign last_o = (step_i == STEP_W'(NUM_MR - 1));
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int unsigned RESET_WAIT = 160000,
  parameter int unsigned CKE_WAIT   = 400000,
  parameter int unsigned MRS_GAP    = 8,
  parameter int unsigned ZQ_WAIT    = 1024,
  parameter int unsigned MR_W       = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         restart_i,
  input  logic [NUM_MR-1:0][MR_W-1:0]  mr_val_i,
  input  logic                         train_done_i,
  output logic                         dram_rst_no,
  output logic                         cke_o,
  output logic                         cmd_valid_o,
  output logic [1:0]                   cmd_op_o,
  output logic [MR_IDX_W-1:0]          mr_idx_o,
  output logic [MR_W-1:0]              mr_val_o,
  output logic                         train_start_o,
  output logic                         init_done_o
);
  localparam int unsigned MAX_A    = (RESET_WAIT > CKE_WAIT) ? RESET_WAIT : CKE_WAIT;
  localparam int unsigned MAX_B    = (MRS_GAP > ZQ_WAIT) ? MRS_GAP : ZQ_WAIT;
  localparam int unsigned MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

  init_st_e state_q, state_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic [CNT_W-1:0]    limit;
  logic                tmr_clr, tmr_first, tmr_last;
  logic [MR_IDX_W-1:0] ord_idx;
  logic                ord_last;

  dram_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .limit_i (limit),
    .first_o (tmr_first),
    .last_o  (tmr_last)
  );

  dram_init_mr_order u_order (
    .step_i (step_q),
    .idx_o  (ord_idx),
    .last_o (ord_last)
  );

  always_comb begin
    unique case (state_q)
      ST_RESET:    limit = CNT_W'(RESET_WAIT);
      ST_CKE_WAIT: limit = CNT_W'(CKE_WAIT);
      ST_MRS:      limit = CNT_W'(MRS_GAP);
      ST_ZQ:       limit = CNT_W'(ZQ_WAIT);
      default:     limit = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    tmr_clr = 1'b0;
    unique case (state_q)
      ST_RESET:    if (tmr_last) begin state_d = ST_CKE_WAIT; tmr_clr = 1'b1; end
      ST_CKE_WAIT: if (tmr_last) begin state_d = ST_MRS;      tmr_clr = 1'b1; end
      ST_MRS: begin
        if (tmr_last) begin
          tmr_clr = 1'b1;
          if (ord_last) begin
            state_d = ST_ZQ;
            step_d  = '0;
          end else begin
            step_d  = step_q + STEP_W'(1);
          end
        end
      end
      ST_ZQ:       if (tmr_last) begin state_d = ST_TRAIN; tmr_clr = 1'b1; end
      ST_TRAIN:    if (train_done_i) state_d = ST_DONE;
      default:     state_d = ST_DONE;
    endcase
    // restart wins over every other event
    if (restart_i) begin
      state_d = ST_RESET;
      step_d  = '0;
      tmr_clr = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  logic issue_mrs, issue_zq;
  assign issue_mrs = (state_q == ST_MRS) && tmr_first;
  assign issue_zq  = (state_q == ST_ZQ)  && tmr_first;

  assign dram_rst_no   = (state_q != ST_RESET);
  assign cke_o         = (state_q != ST_RESET) && (state_q != ST_CKE_WAIT);
  assign cmd_valid_o   = issue_mrs || issue_zq;
  assign cmd_op_o      = issue_mrs ? OP_MRS : (issue_zq ? OP_ZQCL : OP_NOP);
  assign mr_idx_o      = issue_mrs ? ord_idx : '0;
  assign mr_val_o      = issue_mrs ? mr_val_i[ord_idx] : '0;
  assign train_start_o = (state_q == ST_TRAIN);
  assign init_done_o   = (state_q == ST_DONE);

  a_r2_cke_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_rst_no |-> !cke_o);

  a_r3_cmd_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cke_o && dram_rst_no));

  a_r3_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_MRS) |-> (mr_idx_o < MR_IDX_W'(NUM_MR)));

  if (MRS_GAP > 1) begin : g_gap_chk
    a_r4_single_cycle_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_o |=> !cmd_valid_o);
  end

  a_r7_done_follows_train: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> ($past(train_done_i) && $past(train_start_o)));

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && !restart_i) |=> init_done_o);

  a_r9_restart_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!dram_rst_no && !cke_o && !init_done_o && !cmd_valid_o));
endmodule

// File: tb/sim_dram_init_seq.sv
module sim_dram_init_seq;
  localparam int RW = 5, CW = 7, G = 4, ZW = 10, MW = 16;
  localparam int M0 = RW + CW, TZQ = M0 + 7 * G, TTR = TZQ + ZW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, restart_i, train_done_i;
  logic [6:0][MW-1:0] mr_val_i;
  logic dram_rst_no, cke_o, cmd_valid_o, train_start_o, init_done_o;
  logic [1:0] cmd_op_o;
  logic [2:0] mr_idx_o;
  logic [MW-1:0] mr_val_o;

  dram_init_seq #(.RESET_WAIT(RW), .CKE_WAIT(CW), .MRS_GAP(G), .ZQ_WAIT(ZW), .MR_W(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .restart_i(restart_i), .mr_val_i(mr_val_i),
    .train_done_i(train_done_i), .dram_rst_no(dram_rst_no), .cke_o(cke_o),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .mr_idx_o(mr_idx_o),
    .mr_val_o(mr_val_o), .train_start_o(train_start_o), .init_done_o(init_done_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int order [7] = '{3, 6, 5, 4, 2, 1, 0};

  task automatic chk(string tag, int t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
    end
  endtask

  task automatic sample(int t);
    bit e_v = 1'b0;
    logic [1:0] e_op = 2'd0;
    logic [2:0] e_idx = 3'd0;
    logic [MW-1:0] e_val = '0;
    for (int k = 0; k < 7; k++)
      if (t == M0 + k * G) begin
        e_v = 1'b1; e_op = 2'd1; e_idx = 3'(order[k]); e_val = mr_val_i[order[k]];
      end
    if (t == TZQ) begin e_v = 1'b1; e_op = 2'd2; end
    chk("R1 reset_n", t, 32'(dram_rst_no), 32'(t >= RW));
    chk("R2 cke", t, 32'(cke_o), 32'(t >= M0));
    chk("R4 cmd_valid timing", t, 32'(cmd_valid_o), 32'(e_v));
    chk(!e_v ? "R10 idle opcode" : (e_op == 2'd2 ? "R6 calib opcode" : "R3 opcode"), t, 32'(cmd_op_o), 32'(e_op));
    chk(e_v ? "R3 order index" : "R10 idle index", t, 32'(mr_idx_o), 32'(e_idx));
    chk(e_v ? "R5 value" : "R10 idle value", t, 32'(mr_val_o), 32'(e_val));
    chk("R6 train_start", t, 32'(train_start_o), 32'(t >= TTR));
    chk("R8 init_done low", t, 32'(init_done_o), 32'd0);
  endtask

  task automatic walk(bit wait_first, int t_stop, bit td);
    for (int t = 0; t <= t_stop; t++) begin
      if (t > 0 || wait_first) @(negedge clk);
      restart_i = 1'b0;
      train_done_i = td;
      sample(t);
    end
  endtask

  task automatic finish_training(int hold);
    train_done_i = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R7 train_start held", i, 32'(train_start_o), 32'd1);
      chk("R8 init_done waits", i, 32'(init_done_o), 32'd0);
    end
    train_done_i = 1'b1;
    @(negedge clk);
    train_done_i = 1'b0;
    chk("R7 init_done rise", 0, 32'(init_done_o), 32'd1);
    chk("R7 train_start drop", 0, 32'(train_start_o), 32'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 init_done sticky", i, 32'(init_done_o), 32'd1);
      chk("R10 no command when done", i, 32'(cmd_valid_o), 32'd0);
    end
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0; restart_i = 1'b0; train_done_i = 1'b0;
    for (int i = 0; i < 7; i++) mr_val_i[i] = MW'(16'hA000 + i * 16'h0111);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 reset_n in reset", i, 32'(dram_rst_no), 32'd0);
      chk("R2 cke in reset", i, 32'(cke_o), 32'd0);
      chk("R10 no command in reset", i, 32'(cmd_valid_o), 32'd0);
      chk("R8 init_done in reset", i, 32'(init_done_o), 32'd0);
    end
    rst_ni = 1'b1;
    walk(1'b0, TTR + 2, 1'b0);
    finish_training(4);
  endtask

  task automatic t_early_train_done();
    for (int i = 0; i < 7; i++) mr_val_i[i] = MW'(16'h5A00 ^ (i * 16'h1234));
    restart_i = 1'b1;
    walk(1'b1, TTR, 1'b1);
    @(negedge clk);
    train_done_i = 1'b0;
    chk("R7 done after held train_done", 0, 32'(init_done_o), 32'd1);
    chk("R7 train_start cleared", 0, 32'(train_start_o), 32'd0);
  endtask

  task automatic t_restart_mid_mrs();
    restart_i = 1'b1;
    walk(1'b1, M0 + 2 * G, 1'b0);
    restart_i = 1'b1;  // same cycle as third mode-register strobe
    walk(1'b1, TTR + 1, 1'b0);
    finish_training(2);
  endtask

  task automatic t_restart_with_train_done();
    restart_i = 1'b1;
    walk(1'b1, TTR, 1'b0);
    restart_i = 1'b1;
    train_done_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    train_done_i = 1'b0;
    chk("R9 restart beats train_done", 0, 32'(init_done_o), 32'd0);
    chk("R9 reset_n reasserted", 0, 32'(dram_rst_no), 32'd0);
    chk("R9 train_start cleared", 0, 32'(train_start_o), 32'd0);
    walk(1'b0, TTR + 1, 1'b0);
    finish_training(1);
  endtask

  initial begin
    t_reset_state();
    t_early_train_done();
    t_restart_mid_mrs();
    t_restart_with_train_done();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 sequence hung actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule